// File: doc/BRIEF.md
# Indirect Interrupt Router Register File

This block holds the programming state of an interrupt router. It is reached through just two bus registers: a select register and a data window. Software first writes an 8-bit selector to the select register. It then reads or writes the data window. The selector decides whether the window shows the router ID, the version word, or one 32-bit half of a 64-bit per-pin routing entry.

Every routing entry is driven out in parallel to the delivery logic as a flat vector. That logic may set an entry's remote-pending flag when it delivers a level interrupt.

The block reports two kinds of event to the delivery logic as single-cycle pulses:
- A mask-change pulse, which carries the pin index and the new mask value.
- A service-request pulse. It is raised when software writes an entry that is in level mode while that pin's request input is high.

Delivering interrupts is not part of this block.

Top module: `rir_regfile`

## Requirements
- R1: The select register is at bus offset 0x00. A read returns the low 8 bits of the last value written there, with bits 31:8 zero. After reset it reads 0.
- R2: Selector 0x00 is the ID. A window write stores wdata[27:24], and a read returns the ID in bits 27:24 with all other bits zero. Selector 0x02 reads the same value, and writes to it are ignored. After reset the ID is 0.
- R3: Selector 0x01 reads as {8'h00, NPINS-1, 8'h00, VER}. Writes to it are ignored.
- R4: For a selector of 0x10 or above, the entry index is (sel-0x10)>>1. An odd selector reaches bits 63:32 and an even one reaches bits 31:0. Entry i appears on route_entries[i*64+63 : i*64]. The entry layout is: vector 7:0, delivery mode 10:8, destination mode 11, remote flag 14, trigger 15 (1 = level), mask 16, destination 63:56. After reset every entry is 64'h0000_0000_0001_0000.
- R5: The window reads all ones, and ignores writes, for two kinds of selector: 0x03 to 0x0F, and entry indices of NPINS or more.
- R6: A write to an entry's lower half stores bit 14 as 0. A write to its upper half leaves bit 14 unchanged. rirr_set[i] sets bit 14 of entry i, and it takes priority over a lower-half write in the same cycle.
- R7: When a window write changes an entry's mask bit, mask_evt pulses for one cycle in the cycle after the write, with mask_evt_pin equal to the index and mask_evt_val equal to the new mask. A write that leaves the mask unchanged gives no pulse.
- R8: A window write to an entry whose written value has trigger bit 15 set, while pin_req of that index is high at the write edge, pulses svc_req for one cycle in the following cycle, with svc_pin equal to the index. Otherwise there is no pulse.
- R9: Offsets other than 0x00 and 0x10 read 0 and ignore writes. bus_rdata is updated in the cycle after a bus_rd strobe and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte offset, 16-byte aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pin_req | input | NPINS | Request level per pin |
| rirr_set | input | NPINS | Set the remote flag of an entry |
| route_entries | output | NPINS*64 | All routing entries, flattened |
| mask_evt | output | 1 | Mask-change pulse |
| mask_evt_pin | output | IDX_W | Pin whose mask changed |
| mask_evt_val | output | 1 | New mask value |
| svc_req | output | 1 | Level re-service pulse |
| svc_pin | output | IDX_W | Pin to re-service |

## Verification
Every result of this block is due exactly one clock edge after the stimulus that causes it:
- Read data appears on bus_rdata.
- Entry, select and ID updates appear on route_entries and on later reads.
- Mask-change and service pulses appear on mask_evt and svc_req.

The bench drives inputs at the falling edge. Its model updates at the rising edge from the same inputs, and every output is compared at the next falling edge, one edge after the stimulus. Directed checks read the value at the falling edge that follows the strobed cycle. Pulses are checked at that point and again one cycle later, to confirm they have cleared.

// File: rtl/rir_pkg.sv
package rir_pkg;
    localparam logic [7:0] OFS_SEL      = 8'h00;
    localparam logic [7:0] OFS_WIN      = 8'h10;
    localparam logic [7:0] SEL_ID       = 8'h00;
    localparam logic [7:0] SEL_VER      = 8'h01;
    localparam logic [7:0] SEL_ARB      = 8'h02;
    localparam logic [7:0] SEL_TBL_BASE = 8'h10;

    localparam int BIT_REMOTE = 14;
    localparam int BIT_TRIG   = 15;
    localparam int BIT_MASK   = 16;

    localparam logic [63:0] ENT_RST = 64'h0000_0000_0001_0000;

    typedef enum logic [2:0] {
        SK_ID,
        SK_VER,
        SK_ARB,
        SK_ENT,
        SK_NONE
    } sel_kind_e;
endpackage

// File: rtl/rir_sel_decode.sv
module rir_sel_decode
    import rir_pkg::*;
#(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input  logic [7:0]       sel,
    output sel_kind_e        kind,
    output logic [IDX_W-1:0] idx,
    output logic             hi
);
    logic [7:0] offs;
    logic [6:0] raw;

    always_comb begin
        offs = sel - SEL_TBL_BASE;
        raw  = offs[7:1];
        hi   = sel[0];
        idx  = '0;
        kind = SK_NONE;
        if (sel == SEL_ID) begin
            kind = SK_ID;
        end else if (sel == SEL_VER) begin
            kind = SK_VER;
        end else if (sel == SEL_ARB) begin
            kind = SK_ARB;
        end else if (sel >= SEL_TBL_BASE) begin
            if (int'(raw) < NPINS) begin
                kind = SK_ENT;
                idx  = IDX_W'(raw);
            end
        end
    end
endmodule

// File: rtl/rir_entry_slot.sv
module rir_entry_slot
    import rir_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_lo,
    input  logic        wr_hi,
    input  logic [31:0] wdata,
    input  logic        rset,
    output logic [63:0] entry
);
    logic [63:0] entry_d, entry_q;

    always_comb begin
        entry_d = entry_q;
        if (wr_hi) begin
            entry_d[63:32] = wdata;
        end
        if (wr_lo) begin
            entry_d[31:0]       = wdata;
            entry_d[BIT_REMOTE] = 1'b0;
        end
        if (rset) begin
            entry_d[BIT_REMOTE] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            entry_q <= ENT_RST;
        end else begin
            entry_q <= entry_d;
        end
    end

    assign entry = entry_q;
endmodule

// File: rtl/rir_regfile.sv
module rir_regfile
    import rir_pkg::*;
#(
    parameter int         NPINS = 24,
    parameter logic [7:0] VER   = 8'h11,
    localparam int        IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_wr,
    input  logic                  bus_rd,
    input  logic [7:0]            bus_addr,
    input  logic [31:0]           bus_wdata,
    output logic [31:0]           bus_rdata,
    input  logic [NPINS-1:0]      pin_req,
    input  logic [NPINS-1:0]      rirr_set,
    output logic [NPINS*64-1:0]   route_entries,
    output logic                  mask_evt,
    output logic [IDX_W-1:0]      mask_evt_pin,
    output logic                  mask_evt_val,
    output logic                  svc_req,
    output logic [IDX_W-1:0]      svc_pin
);
    typedef struct packed {
        logic [7:0]       sel;
        logic [3:0]       id;
        logic [31:0]      rdata;
        logic             mevt;
        logic [IDX_W-1:0] mpin;
        logic             mval;
        logic             svc;
        logic [IDX_W-1:0] spin;
    } state_t;

    state_t state_d, state_q;

    sel_kind_e        kind;
    logic [IDX_W-1:0] idx;
    logic             hi;
    logic [63:0]      ent [NPINS];
    logic [63:0]      cur;
    logic [63:0]      nxt;
    logic [31:0]      win_rd;
    logic             win_wr;
    logic             sel_wr;
    logic             ent_wr;
    logic [NPINS-1:0] wr_lo;
    logic [NPINS-1:0] wr_hi;

    rir_sel_decode #(
        .NPINS(NPINS),
        .IDX_W(IDX_W)
    ) u_dec (
        .sel (state_q.sel),
        .kind(kind),
        .idx (idx),
        .hi  (hi)
    );

    assign win_wr = bus_wr && (bus_addr == OFS_WIN);
    assign sel_wr = bus_wr && (bus_addr == OFS_SEL);
    assign ent_wr = win_wr && (kind == SK_ENT);

    for (genvar g = 0; g < NPINS; g++) begin : g_slot
        assign wr_lo[g] = ent_wr && !hi && (idx == IDX_W'(g));
        assign wr_hi[g] = ent_wr &&  hi && (idx == IDX_W'(g));

        rir_entry_slot u_slot (
            .clk  (clk),
            .rst_n(rst_n),
            .wr_lo(wr_lo[g]),
            .wr_hi(wr_hi[g]),
            .wdata(bus_wdata),
            .rset (rirr_set[g]),
            .entry(ent[g])
        );

        assign route_entries[g*64 +: 64] = ent[g];
    end

    always_comb begin
        cur = (kind == SK_ENT) ? ent[idx] : '0;
        if (hi) begin
            nxt = {bus_wdata, cur[31:0]};
        end else begin
            nxt = {cur[63:32], bus_wdata};
            nxt[BIT_REMOTE] = 1'b0;
        end
    end

    always_comb begin
        unique case (kind)
            SK_ID, SK_ARB: win_rd = {4'h0, state_q.id, 24'h0};
            SK_VER:        win_rd = {8'h00, 8'(NPINS - 1), 8'h00, VER};
            SK_ENT:        win_rd = hi ? cur[63:32] : cur[31:0];
            default:       win_rd = '1;
        endcase
    end

    always_comb begin
        state_d      = state_q;
        state_d.mevt = 1'b0;
        state_d.svc  = 1'b0;
        if (sel_wr) begin
            state_d.sel = bus_wdata[7:0];
        end
        if (win_wr && (kind == SK_ID)) begin
            state_d.id = bus_wdata[27:24];
        end
        if (ent_wr) begin
            if (nxt[BIT_MASK] != cur[BIT_MASK]) begin
                state_d.mevt = 1'b1;
                state_d.mpin = idx;
                state_d.mval = nxt[BIT_MASK];
            end
            if (nxt[BIT_TRIG] && pin_req[idx]) begin
                state_d.svc  = 1'b1;
                state_d.spin = idx;
            end
        end
        if (bus_rd) begin
            if (bus_addr == OFS_SEL) begin
                state_d.rdata = {24'h0, state_q.sel};
            end else if (bus_addr == OFS_WIN) begin
                state_d.rdata = win_rd;
            end else begin
                state_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata    = state_q.rdata;
    assign mask_evt     = state_q.mevt;
    assign mask_evt_pin = state_q.mpin;
    assign mask_evt_val = state_q.mval;
    assign svc_req      = state_q.svc;
    assign svc_pin      = state_q.spin;
endmodule

// File: rtl/rir_regfile_chk.sv
module rir_regfile_chk #(
    parameter int NPINS = 24,
    parameter int IDX_W = 5
) (
    input logic                clk,
    input logic                rst_n,
    input logic                bus_wr,
    input logic                bus_rd,
    input logic [7:0]          bus_addr,
    input logic [31:0]         bus_rdata,
    input logic [NPINS-1:0]    rirr_set,
    input logic [NPINS*64-1:0] route_entries,
    input logic                mask_evt,
    input logic [IDX_W-1:0]    mask_evt_pin,
    input logic                mask_evt_val,
    input logic                svc_req,
    input logic [IDX_W-1:0]    svc_pin
);
    p_mask_evt_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt |-> ($past(bus_wr) && ($past(bus_addr) == 8'h10)));

    p_mask_evt_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mask_evt |-> (route_entries[int'(mask_evt_pin)*64 + 16] == mask_evt_val));

    p_svc_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        svc_req |-> (route_entries[int'(svc_pin)*64 + 15] && $past(bus_wr)));

    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && (rirr_set == '0)) |=> $stable(route_entries));

    p_rdata_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    for (genvar g = 0; g < NPINS; g++) begin : g_rem
        p_remote_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(route_entries[g*64 + 14]) |-> $past(rirr_set[g]));
    end
endmodule

bind rir_regfile rir_regfile_chk #(
    .NPINS(NPINS),
    .IDX_W(IDX_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_addr     (bus_addr),
    .bus_rdata    (bus_rdata),
    .rirr_set     (rirr_set),
    .route_entries(route_entries),
    .mask_evt     (mask_evt),
    .mask_evt_pin (mask_evt_pin),
    .mask_evt_val (mask_evt_val),
    .svc_req      (svc_req),
    .svc_pin      (svc_pin)
);

// File: tb/rir_regfile_tb.sv
module rir_regfile_tb;
    localparam int NP    = 24;
    localparam int IW    = $clog2(NP);
    localparam logic [7:0] VERC = 8'h11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [7:0]        bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NP-1:0]     pin_req = '0;
    logic [NP-1:0]     rirr_set = '0;
    logic [NP*64-1:0]  route_entries;
    logic              mask_evt;
    logic [IW-1:0]     mask_evt_pin;
    logic              mask_evt_val;
    logic              svc_req;
    logic [IW-1:0]     svc_pin;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc   = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    rir_regfile #(.NPINS(NP), .VER(VERC)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_req(pin_req), .rirr_set(rirr_set), .route_entries(route_entries),
        .mask_evt(mask_evt), .mask_evt_pin(mask_evt_pin), .mask_evt_val(mask_evt_val),
        .svc_req(svc_req), .svc_pin(svc_pin)
    );

    // behavioural reference model
    logic [7:0]  m_sel;
    logic [3:0]  m_id;
    logic [31:0] m_rd;
    logic [63:0] m_ent [NP];
    logic        m_mev, m_mval, m_svc;
    int          m_mpin, m_spin;

    function automatic logic [31:0] model_read(logic [7:0] a);
        int ix;
        if (a == 8'h00) return {24'h0, m_sel};
        if (a != 8'h10) return 32'h0;
        if (m_sel == 8'h00 || m_sel == 8'h02) return {4'h0, m_id, 24'h0};
        if (m_sel == 8'h01) return {8'h00, 8'(NP - 1), 8'h00, VERC};
        if (m_sel < 8'h10) return 32'hFFFF_FFFF;
        ix = (int'(m_sel) - 16) / 2;
        if (ix >= NP) return 32'hFFFF_FFFF;
        return m_sel[0] ? m_ent[ix][63:32] : m_ent[ix][31:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel = 0; m_id = 0; m_rd = 0; m_mev = 0; m_svc = 0;
            m_mval = 0; m_mpin = 0; m_spin = 0;
            for (int i = 0; i < NP; i++) m_ent[i] = 64'h0000_0000_0001_0000;
        end else begin
            m_mev = 0;
            m_svc = 0;
            if (bus_rd) m_rd = model_read(bus_addr);
            if (bus_wr && bus_addr == 8'h00) m_sel = bus_wdata[7:0];
            else if (bus_wr && bus_addr == 8'h10) begin
                if (m_sel == 8'h00) m_id = bus_wdata[27:24];
                else if (m_sel >= 8'h10 && (int'(m_sel) - 16) / 2 < NP) begin
                    int ix;
                    logic [63:0] nv;
                    ix = (int'(m_sel) - 16) / 2;
                    nv = m_ent[ix];
                    if (m_sel[0]) nv[63:32] = bus_wdata;
                    else begin nv[31:0] = bus_wdata; nv[14] = 1'b0; end
                    if (nv[16] != m_ent[ix][16]) begin
                        m_mev = 1; m_mpin = ix; m_mval = nv[16];
                    end
                    if (nv[15] && pin_req[ix]) begin
                        m_svc = 1; m_spin = ix;
                    end
                    m_ent[ix] = nv;
                end
            end
            for (int i = 0; i < NP; i++) if (rirr_set[i]) m_ent[i][14] = 1'b1;
        end
    end

    task automatic chk(string tag, logic [63:0] got, logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (cmp_en && !done) begin
            chk("R9 rdata", 64'(bus_rdata), 64'(m_rd));
            for (int i = 0; i < NP; i++)
                chk("R4 entry", route_entries[i*64 +: 64], m_ent[i]);
            chk("R7 mask_evt", 64'(mask_evt), 64'(m_mev));
            if (m_mev) begin
                chk("R7 mask pin", 64'(mask_evt_pin), 64'(m_mpin));
                chk("R7 mask val", 64'(mask_evt_val), 64'(m_mval));
            end
            chk("R8 svc_req", 64'(svc_req), 64'(m_svc));
            if (m_svc) chk("R8 svc pin", 64'(svc_pin), 64'(m_spin));
        end
    end

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] v);
        bus_rd = 1; bus_addr = a;
        @(negedge clk);
        bus_rd = 0;
        v = bus_rdata;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=<50000", cyc);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        cmp_en = 1'b1;

        // reset state
        rd(8'h00, v);  chk("R1 reset select", 64'(v), 64'h0);
        rd(8'h10, v);  chk("R2 reset id", 64'(v), 64'h0);
        chk("R4 reset entry 0", route_entries[63:0], 64'h0000_0000_0001_0000);
        chk("R4 reset entry last", route_entries[(NP-1)*64 +: 64], 64'h0000_0000_0001_0000);

        // R1 select keeps 8 bits
        wr(8'h00, 32'hABCD_EF01);
        rd(8'h00, v);  chk("R1 select 8 bits", 64'(v), 64'h01);
        // R3 version
        rd(8'h10, v);  chk("R3 version", 64'(v), 64'h0017_0011);
        wr(8'h10, 32'h0);
        rd(8'h10, v);  chk("R3 version write ignored", 64'(v), 64'h0017_0011);

        // R2 ID and arbitration ID
        wr(8'h00, 32'h0);
        wr(8'h10, 32'hF5A0_0000);
        rd(8'h10, v);  chk("R2 id", 64'(v), 64'h0500_0000);
        wr(8'h00, 32'h2);
        rd(8'h10, v);  chk("R2 arb id", 64'(v), 64'h0500_0000);
        wr(8'h10, 32'h0C00_0000);
        rd(8'h10, v);  chk("R2 arb write ignored", 64'(v), 64'h0500_0000);

        // R4/R7 entry 3 lower half, unmask, level
        wr(8'h00, 32'h16);
        wr(8'h10, 32'h0000_8031);
        chk("R7 unmask pulse", 64'(mask_evt), 64'h1);
        chk("R7 unmask pin", 64'(mask_evt_pin), 64'd3);
        chk("R7 unmask val", 64'(mask_evt_val), 64'h0);
        chk("R8 no svc without req", 64'(svc_req), 64'h0);
        @(negedge clk);
        chk("R7 pulse one cycle", 64'(mask_evt), 64'h0);
        wr(8'h00, 32'h17);
        wr(8'h10, 32'hAB00_0000);
        chk("R7 no pulse upper write", 64'(mask_evt), 64'h0);
        rd(8'h10, v);  chk("R4 read upper", 64'(v), 64'hAB00_0000);
        chk("R4 entry 3 port", route_entries[3*64 +: 64], 64'hAB00_0000_0000_8031);

        // R8 service request
        pin_req[3] = 1'b1;
        wr(8'h10, 32'hAC00_0000);
        chk("R8 svc pulse", 64'(svc_req), 64'h1);
        chk("R8 svc pin", 64'(svc_pin), 64'd3);
        @(negedge clk);
        chk("R8 svc one cycle", 64'(svc_req), 64'h0);
        pin_req[5] = 1'b1;
        wr(8'h00, 32'h1A);
        wr(8'h10, 32'h0001_0022);
        chk("R8 no svc edge entry", 64'(svc_req), 64'h0);
        chk("R7 no pulse mask same", 64'(mask_evt), 64'h0);

        // R6 remote flag
        rirr_set[3] = 1'b1; @(negedge clk); rirr_set[3] = 1'b0;
        chk("R6 remote set", 64'(route_entries[3*64 + 14]), 64'h1);
        wr(8'h00, 32'h17);
        wr(8'h10, 32'h1100_0000);
        chk("R6 upper keeps remote", 64'(route_entries[3*64 + 14]), 64'h1);
        wr(8'h00, 32'h16);
        wr(8'h10, 32'h0000_C031);
        chk("R6 lower clears remote", 64'(route_entries[3*64 + 14]), 64'h0);
        rirr_set[3] = 1'b1;
        wr(8'h10, 32'h0000_8031);
        rirr_set[3] = 1'b0;
        chk("R6 set wins over clear", 64'(route_entries[3*64 + 14]), 64'h1);

        // R5 unimplemented selectors
        wr(8'h00, 32'h40);
        rd(8'h10, v);  chk("R5 index NPINS", 64'(v), 64'hFFFF_FFFF);
        wr(8'h10, 32'h0);
        chk("R5 write dropped", route_entries[(NP-1)*64 +: 64], 64'h0000_0000_0001_0000);
        wr(8'h00, 32'h05);
        rd(8'h10, v);  chk("R5 sel 0x05", 64'(v), 64'hFFFF_FFFF);
        wr(8'h00, 32'hFF);
        rd(8'h10, v);  chk("R5 sel 0xFF", 64'(v), 64'hFFFF_FFFF);

        // R9 other offsets
        rd(8'h20, v);  chk("R9 other offset reads 0", 64'(v), 64'h0);
        wr(8'h20, 32'h0000_0033);
        rd(8'h00, v);  chk("R9 other write ignored", 64'(v), 64'hFF);
        @(negedge clk);
        chk("R9 rdata held", 64'(bus_rdata), 64'hFF);

        // mixed traffic checked by the model
        for (int k = 0; k < 600; k++) begin
            int op;
            op = int'($urandom % 8);
            pin_req = NP'($urandom);
            rirr_set = ($urandom % 4 == 0) ? (NP'(1) << ($urandom % NP)) : '0;
            case (op)
                0, 1: wr(8'h00, ($urandom % 4 == 0) ? $urandom : 32'(16 + $urandom % 52));
                2, 3, 4: wr(8'h10, $urandom);
                5: rd(8'h10, v);
                6: rd(8'h00, v);
                default: begin
                    if ($urandom % 2 == 0) rd(8'h30, v);
                    else wr(8'h20, $urandom);
                end
            endcase
            rirr_set = '0;
        end
        @(negedge clk);
        finish_run();
    end
endmodule